// File: doc/BRIEF.md
# LPC Memory-Write Target Decoder

This block sits on the target side of a Low Pin Count bus and recognises host memory-write transactions. On every clock it samples the 4-bit multiplexed LAD bus and the active-low frame strobe. A transaction opens with a start nibble while the frame strobe is low. A cycle-type nibble then marks the transfer as a memory write. Eight address nibbles follow, most significant first, and then two data nibbles, least significant first. After the host's two-clock turnaround, the target answers with a ready sync nibble and then a single turnaround clock of all ones, driving LAD through an output enable.

The target claims only addresses inside two fixed windows: the top 4 MiB of the 32-bit space and the 128 KiB region just below the 1 MiB line. For any other address it stays silent. Each claimed write produces a single-cycle strobe, and the captured address and byte are presented with it so that a storage array or command sequencer next to the decoder can consume them.

Top module: `lpcw_target`

## Requirements
- R1: While reset is low and in the first clock after it is released, `lad_oe` and `wr_stb` are 0.
- R2: A transaction starts in a clock where `frame_n` is 0 and `lad_in` is 4'b0000 (clock 0). In clock 1, a `lad_in` value whose upper three bits are 3'b011 (4'b0110 or 4'b0111) selects a memory write. Any other cycle-type nibble makes the target ignore the transaction.
- R3: Clocks 2 to 9 carry the address, one nibble per clock, with bits 31:28 first. `wr_addr` presents the assembled value.
- R4: Clocks 10 and 11 carry the data byte, bits 3:0 first and then bits 7:4. `wr_data` presents the assembled byte.
- R5: For a claimed write, `lad_oe` is 1 only in clocks 14 and 15. `lad_out` is 4'b0000 in clock 14 and 4'b1111 in clock 15, and `lad_oe` is 0 again from clock 16.
- R6: `wr_stb` is 1 for exactly one clock (clock 14) per claimed write, with `wr_addr` and `wr_data` valid in that clock.
- R7: An address is claimed only if it lies in 0xFFC00000..0xFFFFFFFF or 0x000E0000..0x000FFFFF, both ends included.
- R8: For an unclaimed address or a non-write cycle type, `lad_oe` and `wr_stb` stay 0 for the whole transaction.
- R9: `frame_n` = 0 with `lad_in` = 4'b0000 in any clock restarts decoding at clock 0. `frame_n` = 0 with any other nibble abandons the transaction, and the target returns to idle.
- R10: A new start may be sampled in clock 16 of the previous write, back to back, and is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Value sampled from the LAD bus |
| lad_out | output | 4 | Value the target drives on LAD |
| lad_oe | output | 1 | Output enable for `lad_out` |
| wr_stb | output | 1 | One-clock strobe for an accepted write |
| wr_addr | output | 32 | Captured write address |
| wr_data | output | 8 | Captured write byte |

## Verification
The bench probes the window edges one address on each side: 0xFFBFFFFF, 0x000DFFFF and 0x00100000 must be dropped, and the four end points must be claimed. A comparator that is off by one would claim a dropped edge or miss a claimed one. Byte values with unequal nibbles, such as 0x80 and 0x3C, catch a design that assembles the data high nibble first, because it would strobe a swapped byte. Mid-address restarts and frame-low aborts catch a decoder that keeps stale nibbles or misses a new start, which shows up as a spurious strobe or a lost write. A back-to-back write started in the target's release clock catches a sequencer that needs an extra idle clock.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTYPE,
      ST_ADDR,
      ST_DATA,
      ST_TAR_H,
      ST_TAR_F,
      ST_SYNC,
      ST_TAR_T
   } lpcw_state_e;

   localparam logic [3:0] NIB_START   = 4'b0000;
   localparam logic [3:0] NIB_SYNC_OK = 4'b0000;
   localparam logic [3:0] NIB_ONES    = 4'b1111;

   function automatic logic is_mem_write(input logic [3:0] nib);
      return nib[3:1] == 3'b011;
   endfunction

endpackage

// File: rtl/lpcw_capture.sv
module lpcw_capture
   import lpcw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_addr,
   input  logic              shift_data,
   input  logic [3:0]        lad_in,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   if (ADDR_W % 4 != 0) begin : g_chk_aw
      $error("ADDR_W must be a multiple of 4");
   end
   if (DATA_W % 4 != 0) begin : g_chk_dw
      $error("DATA_W must be a multiple of 4");
   end

   // address: most significant nibble first, shift left
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr <= '0;
      else if (shift_addr) addr <= {addr[ADDR_W-5:0], lad_in};
   end

   // data: least significant nibble first, shift right
   if (DATA_W == 4) begin : g_data_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          data <= '0;
         else if (shift_data) data <= lad_in;
      end
   end else begin : g_data_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          data <= '0;
         else if (shift_data) data <= {lad_in, data[DATA_W-1:4]};
      end
   end

endmodule

// File: rtl/lpcw_window.sv
module lpcw_window
   import lpcw_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = '0,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   if (NUM_WIN < 1) begin : g_chk_nw
      $error("NUM_WIN must be at least 1");
   end

   logic [NUM_WIN-1:0] in_win;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      if (WIN_LO[w] > WIN_HI[w]) begin : g_chk_order
         $error("window lower bound above upper bound");
      end
      assign in_win[w] = (addr >= WIN_LO[w]) && (addr <= WIN_HI[w]);
   end

   assign hit = |in_win;

endmodule

// File: rtl/lpcw_fsm.sv
module lpcw_fsm
   import lpcw_pkg::*;
#(
   parameter int ADDR_NIB = 8,
   parameter int DATA_NIB = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_n,
   input  logic [3:0]  lad_in,
   input  logic        hit,
   output lpcw_state_e st,
   output logic        shift_addr,
   output logic        shift_data
);

   localparam int MAX_NIB = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
   localparam int CNT_W   = $clog2(MAX_NIB + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIB - 1);

   if (ADDR_NIB < 2) begin : g_chk_an
      $error("ADDR_NIB must be at least 2");
   end
   if (DATA_NIB < 1) begin : g_chk_dn
      $error("DATA_NIB must be at least 1");
   end

   lpcw_state_e      st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             start;

   assign start = !frame_n && (lad_in == NIB_START);

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      if (!frame_n) begin
         st_n  = start ? ST_CTYPE : ST_IDLE;
         cnt_n = '0;
      end else begin
         unique case (st)
            ST_IDLE:  st_n = ST_IDLE;
            ST_CTYPE: begin
               st_n  = is_mem_write(lad_in) ? ST_ADDR : ST_IDLE;
               cnt_n = '0;
            end
            ST_ADDR: begin
               if (cnt == ADDR_LAST) begin
                  st_n  = ST_DATA;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == DATA_LAST) begin
                  st_n  = ST_TAR_H;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_TAR_H: st_n = ST_TAR_F;
            ST_TAR_F: st_n = hit ? ST_SYNC : ST_IDLE;
            ST_SYNC:  st_n = ST_TAR_T;
            ST_TAR_T: st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end
   end

   assign shift_addr = frame_n && (st == ST_ADDR);
   assign shift_data = frame_n && (st == ST_DATA);

   AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) != ST_DATA) |-> $past(st) == ST_ADDR); // R3

   AST_MISS_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAR_F && frame_n && !hit) |=> st != ST_SYNC); // R8

   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> st == ST_CTYPE); // R9

endmodule

// File: rtl/lpcw_drive.sv
module lpcw_drive
   import lpcw_pkg::*;
#(
   parameter bit DRIVE_TAR_ONES = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  lpcw_state_e st,
   output logic [3:0]  lad_out,
   output logic        lad_oe,
   output logic        wr_stb
);

   assign wr_stb = (st == ST_SYNC);

   if (DRIVE_TAR_ONES) begin : g_drive_tar
      assign lad_oe  = (st == ST_SYNC) || (st == ST_TAR_T);
      assign lad_out = (st == ST_SYNC) ? NIB_SYNC_OK : NIB_ONES;
   end else begin : g_float_tar
      assign lad_oe  = (st == ST_SYNC);
      assign lad_out = NIB_SYNC_OK;
   end

   AST_OE_ONLY_OWN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
      lad_oe |-> (st == ST_SYNC || st == ST_TAR_T)); // R5

   if (DRIVE_TAR_ONES) begin : g_ast_tar
      AST_SYNC_THEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (lad_oe && lad_out == NIB_SYNC_OK) |=>
            (!lad_oe || (lad_oe && lad_out == NIB_ONES))); // R5
   end

endmodule

// File: rtl/lpcw_target.sv
module lpcw_target
   import lpcw_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 8,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = {32'h000E_0000, 32'hFFC0_0000},
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = {32'h000F_FFFF, 32'hFFFF_FFFF},
   parameter bit DRIVE_TAR_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int ADDR_NIB = ADDR_W / 4;
   localparam int DATA_NIB = DATA_W / 4;

   lpcw_state_e st;
   logic        shift_addr, shift_data, hit;

   lpcw_fsm #(.ADDR_NIB(ADDR_NIB), .DATA_NIB(DATA_NIB)) u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in), .hit(hit),
      .st(st), .shift_addr(shift_addr), .shift_data(shift_data)
   );

   lpcw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .shift_addr(shift_addr), .shift_data(shift_data),
      .lad_in(lad_in), .addr(wr_addr), .data(wr_data)
   );

   lpcw_window #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
      .addr(wr_addr), .hit(hit)
   );

   lpcw_drive #(.DRIVE_TAR_ONES(DRIVE_TAR_ONES)) u_drv (
      .clk(clk), .rst_n(rst_n), .st(st),
      .lad_out(lad_out), .lad_oe(lad_oe), .wr_stb(wr_stb)
   );

   function automatic logic addr_claimed(input logic [ADDR_W-1:0] a);
      logic r;
      r = 1'b0;
      for (int w = 0; w < NUM_WIN; w++)
         if (a >= WIN_LO[w] && a <= WIN_HI[w]) r = 1'b1;
      return r;
   endfunction

   AST_STB_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (lad_oe && lad_out == NIB_SYNC_OK)); // R6

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R6

   AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> addr_claimed(wr_addr)); // R7

   AST_STB_VALUES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($stable(wr_addr) && $stable(wr_data))); // R6

endmodule

// File: tb/lpcw_target_tb_top.sv
module lpcw_target_tb_top;

   localparam time CLK_P = 10ns;
   localparam int  WATCHDOG_CYC = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic        wr_stb;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;

   int n_chk  = 0;
   int n_fail = 0;
   logic [39:0] exp_q[$];
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lpcw_target dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit in_window(input logic [31:0] a);
      return (a >= 32'hFFC0_0000) || (a >= 32'h000E_0000 && a <= 32'h000F_FFFF);
   endfunction

   // drive one nibble at a negedge, advance to the next negedge
   task automatic put(input logic f, input logic [3:0] n);
      frame_n = f;
      lad_in  = n;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) put(1'b1, 4'hF);
   endtask

   // full host write, caller stands at a negedge; returns at the negedge after clock 15
   task automatic lpc_write(input logic [3:0] ctype, input logic [31:0] a, input logic [7:0] d, input string req);
      bit claim;
      claim = ctype[3:1] == 3'b011 && in_window(a);
      if (claim) exp_q.push_back({a, d});
      put(1'b0, 4'h0);
      put(1'b1, ctype);
      for (int i = 7; i >= 0; i--) put(1'b1, a[i*4 +: 4]);
      put(1'b1, d[3:0]);
      put(1'b1, d[7:4]);
      put(1'b1, 4'hF);
      put(1'b1, 4'hF);
      // clock 14
      chk(lad_oe == claim, {req, " sync oe"}, 40'(lad_oe), 40'(claim));
      if (claim) chk(lad_out == 4'h0, "R5 sync nibble", 40'(lad_out), 40'h0);
      put(1'b1, 4'hF);
      // clock 15
      chk(lad_oe == claim, {req, " tar oe"}, 40'(lad_oe), 40'(claim));
      if (claim) chk(lad_out == 4'hF, "R5 tar nibble", 40'(lad_out), 40'hF);
      put(1'b1, 4'hF);
      // clock 16
      chk(lad_oe == 1'b0, "R5 release", 40'(lad_oe), 40'h0);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected strobe", {wr_addr, wr_data}, 40'h0);
            end else begin
               logic [39:0] e;
               e = exp_q.pop_front();
               chk({wr_addr, wr_data} == e, "R3 R4 R6 strobe values", {wr_addr, wr_data}, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      chk(1'b0, "watchdog", 40'h0, 40'h1);
      finish_run();
   end

   initial begin
      // R1 reset
      repeat (3) @(negedge clk);
      chk(lad_oe == 1'b0 && wr_stb == 1'b0, "R1 in reset", {38'h0, lad_oe, wr_stb}, 40'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(lad_oe == 1'b0 && wr_stb == 1'b0, "R1 after reset", {38'h0, lad_oe, wr_stb}, 40'h0);

      // R2/R3/R4 basic writes with both accepted type codes
      lpc_write(4'b0110, 32'hFFFF_5555, 8'hAA, "R2");
      idle(2);
      lpc_write(4'b0111, 32'hFFFF_2AAA, 8'h55, "R2");
      idle(1);
      lpc_write(4'b0110, 32'hFFC1_2345, 8'h80, "R4");
      // R10 back to back, no idle clock
      lpc_write(4'b0110, 32'h000E_5A5A, 8'h3C, "R10");
      lpc_write(4'b0111, 32'hFFF0_0003, 8'h01, "R10");

      // R2 non-write cycle types ignored
      lpc_write(4'b0100, 32'hFFFF_0000, 8'h11, "R2 R8");
      lpc_write(4'b0010, 32'hFFFF_0000, 8'h22, "R2 R8");

      // R7 window edges
      lpc_write(4'b0110, 32'hFFC0_0000, 8'hC1, "R7");
      lpc_write(4'b0110, 32'hFFFF_FFFF, 8'hC2, "R7");
      lpc_write(4'b0110, 32'h000E_0000, 8'hC3, "R7");
      lpc_write(4'b0110, 32'h000F_FFFF, 8'hC4, "R7");
      lpc_write(4'b0110, 32'hFFBF_FFFF, 8'hD1, "R7 R8");
      lpc_write(4'b0110, 32'h000D_FFFF, 8'hD2, "R7 R8");
      lpc_write(4'b0110, 32'h0010_0000, 8'hD3, "R7 R8");
      lpc_write(4'b0110, 32'h1234_5678, 8'hD4, "R8");

      // R9 restart in the middle of the address
      put(1'b0, 4'h0);
      put(1'b1, 4'h6);
      put(1'b1, 4'hF); put(1'b1, 4'hF); put(1'b1, 4'hC);
      lpc_write(4'b0110, 32'hFFD0_0010, 8'h7E, "R9 restart");

      // R9 frame low with non-start nibble abandons the cycle
      put(1'b0, 4'h0);
      put(1'b1, 4'h6);
      put(1'b1, 4'hF); put(1'b1, 4'hF);
      put(1'b0, 4'h5);
      for (int i = 0; i < 11; i++) begin
         put(1'b1, 4'hF);
         chk(lad_oe == 1'b0, "R9 abandon", 40'(lad_oe), 40'h0);
      end

      // R9 restart during the data phase
      put(1'b0, 4'h0);
      put(1'b1, 4'h7);
      for (int i = 7; i >= 0; i--) put(1'b1, 4'hF);
      put(1'b1, 4'h9);
      lpc_write(4'b0110, 32'h000E_0001, 8'h96, "R9 restart data");

      idle(4);
      chk(exp_q.size() == 0, "R6 all strobes seen", 40'(exp_q.size()), 40'h0);
      chk(lad_oe == 1'b0, "R5 idle quiet", 40'(lad_oe), 40'h0);
      finish_run();
   end

endmodule